// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for software that has stopped making progress. A counter runs on the system clock and is restarted by a strobe from software. If no restart arrives within a selectable timeout, the block sets a sticky interrupt flag. It raises an interrupt request when that flag is enabled. If software still does not restart the counter, a fixed window later the block emits a single-cycle soft-reset request. After that request the whole sequence starts again from zero.

Control uses plain register-style strobes. A configuration write loads a two-bit timeout select and an interrupt enable together. There is also a restart strobe and a write-1 flag clear. All timing is counted in cycles of the block's clock. Three parameters scale the timeout exponents. The defaults give the full-length timeouts, and smaller values let a simulation reach every stage quickly with the same ordering.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, sel_o is 00, and flag_o, irq_o and rst_req_o are 0. The interrupt-stage count starts from zero at the first clock edge after reset is released.
- R2: rst_req_o rises exactly W = 2^WIN_LOG2 cycles (default 2^9) after the edge on which flag_o was set, provided no restart arrives in between.
- R3: flag_o becomes 1 exactly L cycles after the last count restart. L = 2^(BASE_LOG2 + code*STEP_LOG2), where code is the select value. With the defaults this is 2^12, 2^15, 2^18 and 2^21 for codes 00, 01, 10 and 11.
- R4: irq_o is 1 exactly when flag_o is 1 and the stored interrupt enable is 1.
- R5: A restart_i strobe clears the count in either stage and returns the block to the interrupt stage. It cancels a pending reset request and leaves flag_o unchanged.
- R6: rst_req_o is high for a single cycle. On the same edge the count restarts in the interrupt stage, so the next flag comes L cycles later.
- R7: In the interrupt stage, a configuration write whose select differs from sel_o clears the count. A write of the same select value does not clear it.
- R8: A select write made during the reset window updates sel_o. It does not move the pending reset request. The new timeout applies from the following interrupt stage onward.
- R9: flag_o stays 1 until a flag_clr_i strobe clears it. A timeout on the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the count source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Strobe that loads cfg_sel_i and cfg_irq_en_i |
| cfg_sel_i | input | 2 | Timeout select code |
| cfg_irq_en_i | input | 1 | Interrupt enable value |
| restart_i | input | 1 | Software restart strobe |
| flag_clr_i | input | 1 | Write-1 clear of the interrupt flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle soft-reset request |
| flag_o | output | 1 | Sticky timeout flag |
| sel_o | output | 2 | Current select code |

## Verification
The hardest situations to reach are races at the boundaries of a stage. One is a restart landing on the very last cycle of the reset window. Another is a select rewrite that arrives while the reset window is already open. The bench runs a scaled configuration, so every stage of every select code completes in tens to a few hundred cycles. It places each strobe on an exact cycle, counted from a known restart edge. It then checks the outputs on the cycles just before and just after each expected transition.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    STG_IRQ = 1'b0,
    STG_WIN = 1'b1
  } wdt_stage_e;
endpackage

// File: rtl/wdt_limit.sv
module wdt_limit #(
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned WIN_LOG2  = 9,
  parameter int unsigned CNT_W     = 23
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] lim_last_o,
  output logic [CNT_W-1:0] win_last_o
);
  logic [CNT_W-1:0] last_tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_tbl
    localparam int unsigned EXP = BASE_LOG2 + g * STEP_LOG2;
    assign last_tbl[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  assign lim_last_o = last_tbl[sel_i];
  assign win_last_o = CNT_W'((64'd1 << WIN_LOG2) - 64'd1);
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       cfg_irq_en_i,
  input  logic       flag_clr_i,
  input  logic       timeout_i,
  output logic [1:0] sel_o,
  output logic       sel_chg_o,
  output logic       flag_o,
  output logic       irq_o
);
  logic [1:0] sel_q;
  logic       en_q;
  logic       flag_q;

  assign sel_chg_o = cfg_wr_i && (cfg_sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 2'b00;
      en_q  <= 1'b0;
    end else if (cfg_wr_i) begin
      sel_q <= cfg_sel_i;
      en_q  <= cfg_irq_en_i;
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (timeout_i)  flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign sel_o  = sel_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_q;

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr_i |=> flag_q);
  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> flag_q);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             sel_chg_i,
  input  logic [CNT_W-1:0] lim_last_i,
  input  logic [CNT_W-1:0] win_last_i,
  output logic             timeout_o,
  output logic             rst_req_o
);
  wdt_stage_e       stage_q, stage_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_req_d, rst_req_q;
  logic             irq_done, win_done;

  assign irq_done  = (stage_q == STG_IRQ) && (cnt_q == lim_last_i);
  assign win_done  = (stage_q == STG_WIN) && (cnt_q == win_last_i);
  assign timeout_o = irq_done && !restart_i && !sel_chg_i;

  always_comb begin
    stage_d   = stage_q;
    cnt_d     = cnt_q + 1'b1;
    rst_req_d = 1'b0;
    if (restart_i) begin
      stage_d = STG_IRQ;
      cnt_d   = '0;
    end else if (stage_q == STG_IRQ) begin
      if (sel_chg_i) begin
        cnt_d = '0;
      end else if (irq_done) begin
        stage_d = STG_WIN;
        cnt_d   = '0;
      end
    end else if (win_done) begin
      stage_d   = STG_IRQ;
      cnt_d     = '0;
      rst_req_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= STG_IRQ;
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      cnt_q     <= cnt_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign rst_req_o = rst_req_q;

  assert_cnt_in_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_IRQ |-> cnt_q <= lim_last_i);
  assert_cnt_in_win_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_WIN |-> cnt_q <= win_last_i);
  assert_rst_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
  assert_rst_from_win_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |-> stage_q == STG_IRQ && cnt_q == '0);
  assert_restart_cancels_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !rst_req_q && cnt_q == '0);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned WIN_LOG2  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       cfg_irq_en_i,
  input  logic       restart_i,
  input  logic       flag_clr_i,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       flag_o,
  output logic [1:0] sel_o
);
  localparam int unsigned TOP_LOG2 = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int unsigned CNT_W    = ((TOP_LOG2 > WIN_LOG2) ? TOP_LOG2 : WIN_LOG2) + 1;

  logic [CNT_W-1:0] lim_last, win_last;
  logic             sel_chg, timeout;
  logic [1:0]       sel;

  wdt_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_irq_en_i (cfg_irq_en_i),
    .flag_clr_i   (flag_clr_i),
    .timeout_i    (timeout),
    .sel_o        (sel),
    .sel_chg_o    (sel_chg),
    .flag_o       (flag_o),
    .irq_o        (irq_o)
  );

  wdt_limit #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .WIN_LOG2  (WIN_LOG2),
    .CNT_W     (CNT_W)
  ) u_limit (
    .sel_i      (sel),
    .lim_last_o (lim_last),
    .win_last_o (win_last)
  );

  wdt_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .sel_chg_i  (sel_chg),
    .lim_last_i (lim_last),
    .win_last_i (win_last),
    .timeout_o  (timeout),
    .rst_req_o  (rst_req_o)
  );

  assign sel_o = sel;

  assert_sel_follows_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> sel_o == $past(cfg_sel_i));
endmodule

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  localparam int unsigned BASE = 4;
  localparam int unsigned STEP = 1;
  localparam int unsigned WLOG = 3;
  localparam int W = 1 << WLOG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, restart = 1'b0, flag_clr = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic irq, rst_req, flag;
  logic [1:0] sel;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wdt_two_stage #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .WIN_LOG2(WLOG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
    .cfg_irq_en_i(cfg_en), .restart_i(restart), .flag_clr_i(flag_clr),
    .irq_o(irq), .rst_req_o(rst_req), .flag_o(flag), .sel_o(sel)
  );

  function automatic int lim(input int code);
    return 1 << (BASE + code * STEP);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_wr = 0; restart = 0; flag_clr = 0;
    tick(2);
    rst_n = 1'b1;
  endtask

  // config write plus restart on one edge (edge e0)
  task automatic start(input logic [1:0] s, input logic en);
    cfg_wr = 1; cfg_sel = s; cfg_en = en; restart = 1;
    tick(1);
    cfg_wr = 0; restart = 0;
  endtask

  task automatic wr_cfg(input logic [1:0] s, input logic en);
    cfg_wr = 1; cfg_sel = s; cfg_en = en;
    tick(1);
    cfg_wr = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1;
    tick(1);
    flag_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(sel == 2'b00, "R1 sel", sel, 0);
    chk(!flag && !irq && !rst_req, "R1 outputs", {flag, irq, rst_req}, 0);

    // R2 R3 R4 R6 R9: sweep all codes
    for (int s = 0; s < 4; s++) begin
      int L;
      L = lim(s);
      do_reset();
      start(2'(s), 1'b1);
      tick(L - 1);
      chk(!flag, "R3 early", flag, 0);
      chk(!irq, "R4 early", irq, 0);
      tick(1);
      chk(flag, "R3 on time", flag, 1);
      chk(irq, "R4 enabled", irq, 1);
      tick(W - 1);
      chk(!rst_req, "R2 early", rst_req, 0);
      tick(1);
      chk(rst_req, "R2 on time", rst_req, 1);
      tick(1);
      chk(!rst_req, "R6 single pulse", rst_req, 0);
      chk(flag, "R9 held", flag, 1);
      clr_flag();
      chk(!flag, "R9 cleared", flag, 0);
      tick(L - 3);
      chk(!flag, "R6 recount early", flag, 0);
      tick(1);
      chk(flag, "R6 recount", flag, 1);
    end

    // R4 disabled enable
    do_reset();
    start(2'b00, 1'b0);
    tick(lim(0));
    chk(flag && !irq, "R4 masked", {flag, irq}, 2);
    wr_cfg(2'b00, 1'b1);
    chk(irq, "R4 unmasked", irq, 1);

    // R5 restart on last window cycle
    do_reset();
    start(2'b00, 1'b1);
    tick(lim(0));
    tick(W - 1);
    restart = 1;
    tick(1);
    restart = 0;
    chk(!rst_req, "R5 reset cancelled", rst_req, 0);
    chk(flag, "R5 flag kept", flag, 1);
    clr_flag();
    chk(!flag, "R5 clear", flag, 0);
    tick(lim(0) - 2);
    chk(!flag, "R5 recount early", flag, 0);
    tick(1);
    chk(flag, "R5 recount", flag, 1);

    // R9 clear and timeout on the same edge
    do_reset();
    start(2'b00, 1'b1);
    tick(lim(0) - 1);
    flag_clr = 1;
    tick(1);
    flag_clr = 0;
    chk(flag, "R9 set wins", flag, 1);

    // R7 differing select clears count
    do_reset();
    start(2'b00, 1'b1);
    tick(9);
    wr_cfg(2'b01, 1'b1);
    tick(lim(1) - 1);
    chk(!flag, "R7 restarted early", flag, 0);
    tick(1);
    chk(flag, "R7 restarted", flag, 1);

    // R7 same select does not clear
    do_reset();
    start(2'b01, 1'b1);
    tick(9);
    wr_cfg(2'b01, 1'b1);
    chk(sel == 2'b01, "R7 sel", sel, 1);
    tick(lim(1) - 11);
    chk(!flag, "R7 same early", flag, 0);
    tick(1);
    chk(flag, "R7 same kept count", flag, 1);

    // R8 select rewrite inside window
    do_reset();
    start(2'b00, 1'b1);
    tick(lim(0));
    tick(2);
    wr_cfg(2'b11, 1'b1);
    chk(sel == 2'b11, "R8 sel updated", sel, 3);
    tick(W - 4);
    chk(!rst_req, "R8 early", rst_req, 0);
    tick(1);
    chk(rst_req, "R8 window kept", rst_req, 1);
    clr_flag();
    tick(lim(3) - 2);
    chk(!flag, "R8 new timeout early", flag, 0);
    tick(1);
    chk(flag, "R8 new timeout", flag, 1);

    // R1 reset restores select; count from release
    do_reset();
    chk(sel == 2'b00, "R1 sel restored", sel, 0);
    chk(!flag && !rst_req, "R1 cleared", {flag, rst_req}, 0);
    tick(lim(0) - 1);
    chk(!flag, "R1 count early", flag, 0);
    tick(1);
    chk(flag, "R1 count from release", flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule